// File: doc/BRIEF.md
# Run-Boundary Entropy Pipeline

This block turns the run-boundary bitmap of one sorted pixel window into the local Shannon entropy of that window, in bits, as an unsigned fixed-point number. For an S×S window there are N = S² samples. After sorting, bit i of the bitmap is 1 when sorted samples i and i+1 differ and 0 when they are equal, so the bitmap has N−1 bits. The block runs through the bitmap one bit per pipeline stage. Each stage tracks the length of the run that is still open and the partial entropy sum. When a run closes, the stage adds that run's term −(c/N)·log2(c/N), read from a constant table indexed by run length c. A last stage adds the term for the final open run.

One bitmap may enter on every clock, marked by a valid strobe. Results leave in input order after a fixed latency, one per clock. No histogram of intensities is stored, so the cost depends only on N and not on the pixel word length. The table has N+1 entries, and entry 0 holds zero.

Top module: `bitmap_entropy_pipe`

## Requirements
- R1: While the synchronous active-high reset is held and on the first clock after it, o_valid is 0 and o_entropy is 0.
- R2: A bitmap accepted with i_valid=1 on a rising edge produces o_valid=1 with its result exactly N rising edges later (9 for the default 3×3 window). Back-to-back inputs give back-to-back outputs in the same order.
- R3: An all-zero bitmap (all samples equal) gives an entropy of exactly 0.
- R4: An all-one bitmap (all samples distinct) gives log2(N) within 8 LSB.
- R5: For any bitmap, o_entropy equals Σ −(c/N)·log2(c/N) within 8 LSB. The sum runs over the run lengths c, where a run ends at each 1 bit and after the last sample. o_entropy is unsigned Q4.12: value = o_entropy / 4096.
- R6: The first boundary bit sets the first run. Bitmap 0x01 (bit 0 only) gives runs {1, N−1}, and bitmap 0xFE gives runs {2, 1, …, 1}. Both results follow R5.
- R7: A bitmap and its bit-reversed copy have the same multiset of run lengths, so they give bit-identical results.
- R8: A clock with i_valid=0 leaves a one-cycle gap in o_valid N cycles later and produces no result.
- R9: Asserting reset discards every bitmap in flight. None of them appears on the outputs, and a bitmap sent after reset is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Bitmap on i_bitmap is valid this cycle |
| i_bitmap | input | WIN*WIN-1 | Run-boundary bitmap; bit i is 1 when sorted samples i and i+1 differ |
| o_valid | output | 1 | o_entropy holds a result |
| o_entropy | output | FX_W | Entropy in bits, unsigned, FRAC_W fractional bits |

## Verification
A stage that extends or closes a run wrongly changes the set of run lengths. That shows at the ports as an entropy value off by at least one table term, and it appears exactly N cycles after the offending bitmap. Reversed-pair inputs and the uniform and all-distinct extremes expose errors that depend on where a boundary falls or on how the first and last runs are handled. A broken valid chain or reset path shows as missing, extra or misplaced o_valid pulses, measured against the cycle the bitmap was sent.

// File: rtl/ent_pkg.sv
package ent_pkg;

    // Internal fractional precision used while building the table
    localparam int LOG_FR = 24;

    typedef enum logic {
        RUN_EXTEND = 1'b0,
        RUN_CLOSE  = 1'b1
    } run_act_e;

    // log2(x) for integer x >= 1, returned with LOG_FR fractional bits
    function automatic longint log2_fx(longint x);
        longint y;
        longint frac;
        int     ip;
        ip = 0;
        while ((x >> (ip + 1)) != 0) ip++;
        y    = (x << LOG_FR) >> ip;
        frac = 0;
        for (int i = 0; i < LOG_FR; i++) begin
            y    = (y * y) >> LOG_FR;
            frac = frac << 1;
            if (y >= (longint'(2) << LOG_FR)) begin
                y    = y >> 1;
                frac = frac | 1;
            end
        end
        return (longint'(ip) << LOG_FR) | frac;
    endfunction

    // -(k/n)*log2(k/n), rounded to fr fractional bits; zero for k == 0
    function automatic longint ent_term(int k, int n, int fr);
        longint d;
        longint v;
        if (k == 0) return 0;
        d = log2_fx(longint'(n)) - log2_fx(longint'(k));
        v = (longint'(k) * d) / longint'(n);
        return (v + (longint'(1) << (LOG_FR - fr - 1))) >>> (LOG_FR - fr);
    endfunction

endpackage

// File: rtl/entropy_lut_rom.sv
module entropy_lut_rom #(
    parameter int N      = 9,
    parameter int FX_W   = 16,
    parameter int FRAC_W = 12,
    localparam int AW    = $clog2(N + 1)
) (
    input  logic [AW-1:0]   addr,
    output logic [FX_W-1:0] data
);
    logic [FX_W-1:0] tbl [0:N];

    for (genvar k = 0; k <= N; k++) begin : g_ent
        localparam logic [FX_W-1:0] VAL = FX_W'(ent_pkg::ent_term(k, N, FRAC_W));
        assign tbl[k] = VAL;
    end

    assign data = (addr <= AW'(N)) ? tbl[addr] : '0;
endmodule

// File: rtl/entropy_stage.sv
module entropy_stage #(
    parameter int N      = 9,
    parameter int FX_W   = 16,
    parameter int FRAC_W = 12,
    localparam int AW    = $clog2(N + 1),
    localparam int BW    = N - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [BW-1:0]   bits_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [AW-1:0]   cnt_i,
    input  logic [FX_W-1:0] sum_i,
    output logic            vld_o,
    output logic [BW-1:0]   bits_o,
    output logic [AW-1:0]   addr_o,
    output logic [AW-1:0]   cnt_o,
    output logic [FX_W-1:0] sum_o
);
    import ent_pkg::*;

    run_act_e        act;
    logic [FX_W-1:0] term;

    assign act = run_act_e'(bits_i[0]);

    entropy_lut_rom #(.N(N), .FX_W(FX_W), .FRAC_W(FRAC_W)) rom_i (
        .addr (addr_i),
        .data (term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            bits_o <= '0;
            addr_o <= '0;
            cnt_o  <= '0;
            sum_o  <= '0;
        end else begin
            vld_o  <= vld_i;
            bits_o <= bits_i >> 1;
            cnt_o  <= cnt_i + AW'(1);
            if (act == RUN_CLOSE) begin
                sum_o  <= sum_i + term;
                addr_o <= AW'(1);
            end else begin
                sum_o  <= sum_i;
                addr_o <= addr_i + AW'(1);
            end
        end
    end

    // R5
    run_within_count_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |-> (addr_i >= AW'(1)) && (addr_i <= cnt_i));

    // R5
    sum_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> sum_o >= $past(sum_i));

    // R5
    extend_keeps_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !bits_i[0]) |=> (sum_o == $past(sum_i)) && (addr_o == $past(addr_i) + AW'(1)));

    // R5
    close_restarts_run_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && bits_i[0]) |=> addr_o == AW'(1));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    // R8
    bubble_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);
endmodule

// File: rtl/entropy_finish.sv
module entropy_finish #(
    parameter int N      = 9,
    parameter int FX_W   = 16,
    parameter int FRAC_W = 12,
    localparam int AW    = $clog2(N + 1),
    localparam int BW    = N - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_i,
    input  logic [BW-1:0]   bits_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [AW-1:0]   cnt_i,
    input  logic [FX_W-1:0] sum_i,
    output logic            vld_o,
    output logic [FX_W-1:0] ent_o
);
    logic [FX_W-1:0] term;

    entropy_lut_rom #(.N(N), .FX_W(FX_W), .FRAC_W(FRAC_W)) rom_i (
        .addr (addr_i),
        .data (term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            ent_o <= '0;
        end else begin
            vld_o <= vld_i;
            ent_o <= sum_i + term;
        end
    end

    // R5
    all_samples_seen_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |-> (cnt_i == AW'(N)) && (bits_i == '0));

    // R5
    last_run_added_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> ent_o >= $past(sum_i));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> !vld_o && (ent_o == '0));
endmodule

// File: rtl/bitmap_entropy_pipe.sv
module bitmap_entropy_pipe #(
    parameter int WIN    = 3,
    parameter int FX_W   = 16,
    parameter int FRAC_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_valid,
    input  logic [WIN*WIN-2:0]   i_bitmap,
    output logic                 o_valid,
    output logic [FX_W-1:0]      o_entropy
);
    localparam int N  = WIN * WIN;
    localparam int BW = N - 1;
    localparam int AW = $clog2(N + 1);

    // Index 0 is the seed state; index j is the output of stage j-1
    logic            vld_s  [0:N-1];
    logic [BW-1:0]   bits_s [0:N-1];
    logic [AW-1:0]   addr_s [0:N-1];
    logic [AW-1:0]   cnt_s  [0:N-1];
    logic [FX_W-1:0] sum_s  [0:N-1];

    // Seed: one sample seen, open run of length one, nothing summed
    assign vld_s[0]  = i_valid;
    assign bits_s[0] = i_bitmap;
    assign addr_s[0] = AW'(1);
    assign cnt_s[0]  = AW'(1);
    assign sum_s[0]  = '0;

    for (genvar j = 0; j < BW; j++) begin : g_stage
        entropy_stage #(.N(N), .FX_W(FX_W), .FRAC_W(FRAC_W)) stage_i (
            .clk    (clk),
            .rst    (rst),
            .vld_i  (vld_s[j]),
            .bits_i (bits_s[j]),
            .addr_i (addr_s[j]),
            .cnt_i  (cnt_s[j]),
            .sum_i  (sum_s[j]),
            .vld_o  (vld_s[j+1]),
            .bits_o (bits_s[j+1]),
            .addr_o (addr_s[j+1]),
            .cnt_o  (cnt_s[j+1]),
            .sum_o  (sum_s[j+1])
        );
    end

    entropy_finish #(.N(N), .FX_W(FX_W), .FRAC_W(FRAC_W)) finish_i (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_s[N-1]),
        .bits_i (bits_s[N-1]),
        .addr_i (addr_s[N-1]),
        .cnt_i  (cnt_s[N-1]),
        .sum_i  (sum_s[N-1]),
        .vld_o  (o_valid),
        .ent_o  (o_entropy)
    );
endmodule

// File: tb/bitmap_entropy_pipe_tb_top.sv
`timescale 1ns/1ps
module bitmap_entropy_pipe_tb_top;
    localparam int WIN = 3;
    localparam int N   = WIN * WIN;
    localparam int BW  = N - 1;
    localparam int TOL = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          i_valid = 1'b0;
    logic [BW-1:0] i_bitmap = '0;
    logic          o_valid;
    logic [15:0]   o_entropy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    int act_q [$];
    int ts_q  [$];
    int snd_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitmap_entropy_pipe #(.WIN(WIN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .i_valid   (i_valid),
        .i_bitmap  (i_bitmap),
        .o_valid   (o_valid),
        .o_entropy (o_entropy)
    );

    always @(negedge clk) begin
        if (o_valid) begin
            act_q.push_back(int'(o_entropy));
            ts_q.push_back(cyc);
        end
    end

    function automatic real term(int c);
        real p;
        p = real'(c) / real'(N);
        return -p * $ln(p) / $ln(2.0);
    endfunction

    function automatic int expect_fx(logic [BW-1:0] b);
        real h;
        int  c;
        h = 0.0;
        c = 1;
        for (int i = 0; i < BW; i++) begin
            if (b[i]) begin
                h = h + term(c);
                c = 1;
            end else begin
                c = c + 1;
            end
        end
        h = h + term(c);
        return int'(h * 4096.0 + 0.5);
    endfunction

    task automatic check(string req, int act, int exp, int tol);
        int diff;
        total++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_q();
        act_q.delete();
        ts_q.delete();
        snd_q.delete();
    endtask

    task automatic send(logic [BW-1:0] b);
        @(negedge clk);
        i_valid  = 1'b1;
        i_bitmap = b;
        snd_q.push_back(cyc);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            i_valid = 1'b0;
        end
    endtask

    task automatic drain();
        idle(N + 3);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        i_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 valid in reset", int'(o_valid), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(o_valid), 0, 0);
        check("R1 entropy after reset", int'(o_entropy), 0, 0);
    endtask

    task automatic t_latency_uniform();
        clear_q();
        send('0);
        drain();
        check("R2 single count", act_q.size(), 1, 0);
        if (act_q.size() == 1) begin
            check("R2 latency", ts_q[0] - snd_q[0], N, 0);
            check("R3 uniform window", act_q[0], 0, 0);
        end
    endtask

    task automatic t_distinct();
        clear_q();
        send('1);
        drain();
        check("R4 count", act_q.size(), 1, 0);
        if (act_q.size() == 1)
            check("R4 all distinct", act_q[0], int'($ln(real'(N)) / $ln(2.0) * 4096.0 + 0.5), TOL);
    endtask

    task automatic t_first_boundary();
        clear_q();
        send(8'h01);
        send(8'hFE);
        drain();
        check("R6 count", act_q.size(), 2, 0);
        if (act_q.size() == 2) begin
            check("R6 bit0 only", act_q[0], expect_fx(8'h01), TOL);
            check("R6 all but bit0", act_q[1], expect_fx(8'hFE), TOL);
        end
    endtask

    task automatic t_reverse_pairs();
        logic [BW-1:0] pats [3];
        pats[0] = 8'h01;
        pats[1] = 8'h0B;
        pats[2] = 8'h37;
        clear_q();
        for (int i = 0; i < 3; i++) begin
            send(pats[i]);
            send({<<{pats[i]}});
        end
        drain();
        check("R7 count", act_q.size(), 6, 0);
        if (act_q.size() == 6)
            for (int i = 0; i < 3; i++)
                check("R7 reversed equal", act_q[2*i+1], act_q[2*i], 0);
    endtask

    task automatic t_stream();
        logic [BW-1:0] pats [16];
        for (int i = 0; i < 16; i++) pats[i] = BW'(i * 37 + 5);
        pats[0] = 8'h66;
        clear_q();
        for (int i = 0; i < 16; i++) send(pats[i]);
        drain();
        check("R2 stream count", act_q.size(), 16, 0);
        if (act_q.size() == 16) begin
            check("R5 run counts 2,1,3,1,2", act_q[0], 8999, TOL);
            for (int i = 0; i < 16; i++) begin
                check("R5 stream value", act_q[i], expect_fx(pats[i]), TOL);
                check("R2 stream timing", ts_q[i] - snd_q[i], N, 0);
            end
        end
    endtask

    task automatic t_bubbles();
        clear_q();
        send(8'h66);
        idle(2);
        send(8'h81);
        drain();
        check("R8 count", act_q.size(), 2, 0);
        if (act_q.size() == 2) begin
            check("R8 gap", ts_q[1] - ts_q[0], 3, 0);
            check("R8 second value", act_q[1], expect_fx(8'h81), TOL);
        end
    endtask

    task automatic t_mid_reset();
        clear_q();
        send(8'hAA);
        send(8'h55);
        send(8'h0F);
        do_reset();
        drain();
        check("R9 flushed", act_q.size(), 0, 0);
        clear_q();
        send(8'h3C);
        drain();
        check("R9 count after", act_q.size(), 1, 0);
        if (act_q.size() == 1)
            check("R9 value after", act_q[0], expect_fx(8'h3C), TOL);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(o_valid), 0, 0);
        check("R1 entropy in reset", int'(o_entropy), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(o_valid), 0, 0);
        t_latency_uniform();
        t_distinct();
        t_first_boundary();
        t_reverse_pairs();
        t_stream();
        t_bubbles();
        t_mid_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule